// File: doc/BRIEF.md
# Dual-Mode PWM and Digital Comparator

This block is an 8-bit unit with two functions. As a pulse-width modulator, it drives a positive output and its complement, with a programmable dead band between them. As a magnitude comparator, it raises a match flag when operand A exceeds operand B. A single configuration bit picks the function. The second output is shared: it carries the complementary PWM in one function and the match flag in the other.

A second bit sets the convention used by both functions. With that bit at 0, the duty cycle can fall to 0% and the comparator tests A > B. With it at 1, the duty cycle can reach 100% and the comparator tests A >= B. Each operand comes from a four-way multiplexer over plain input ports.

The block runs on a fast timing clock with a nominal 10 ns period. The unit's own clock is one of two slower clock inputs. That input is synchronised and edge-detected into a single-cycle tick, on its rising edge or, when inverted, its falling edge. Every pin is a plain level. No data stream crosses the block edge, so there is no handshake and no back-pressure.

Top module: `pwmcmp_top`

## Requirements
- R1: With func_sel = 0 the block is a PWM: pwm_p and out_n are complementary. With func_sel = 1, pwm_p is held low and out_n shows the registered compare result.
- R2: In comparator mode, out_n is high when A > B if mode_sel = 0, and when A >= B if mode_sel = 1. The result is registered on the active tick.
- R3: The PWM counter advances once per tick with a period of 256 ticks. Let H be the number of ticks per period in which the raw PWM is high. H = B when mode_sel = 0 and H = B + 1 when mode_sel = 1. So B = 0 in mode 0 gives 0%, and B = 255 in mode 1 gives 100%.
- R4: Let D = DB_UNIT << db_sel fast cycles (with DB_UNIT = 1: codes 00, 01, 10, 11 give 1, 2, 4, 8 cycles). The rising edge of each PWM output is delayed by D cycles and the falling edge is not delayed. With T fast cycles per tick, pwm_p is high for H*T - D cycles per period and out_n for (256 - H)*T - D cycles. At H = 0 or H = 256 the output that is always on stays high all period.
- R5: pwm_p and out_n are never high in the same cycle.
- R6: The A operand select a_sel picks 0 = adc_data, 1 = spi_word[15:8], 2 = fsm_val, 3 = a_const.
- R7: The B operand select b_sel picks 0 = fsm_val, 1 = b_const, 2 = spi_word[7:0], 3 = cnt_low.
- R8: With clk_src = 0 the tick follows div_clk_in. With clk_src = 1 it follows route_clk_in.
- R9: With clk_inv = 0 the active edge is the rising edge of the selected clock, and with clk_inv = 1 it is the falling edge. The state changes on the third fast-clock edge after the active edge.
- R10: While en = 0, both outputs are low from the next fast cycle on. The PWM counter is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock (nominal 10 ns) |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Register enable |
| func_sel | input | 1 | 0 = PWM, 1 = comparator |
| mode_sel | input | 1 | Duty and compare convention |
| db_sel | input | 2 | Dead-band code |
| clk_inv | input | 1 | Run on the falling edge of the selected clock |
| clk_src | input | 1 | 0 = divided clock, 1 = routed clock |
| div_clk_in | input | 1 | Shared divided clock |
| route_clk_in | input | 1 | Separate routed clock |
| a_sel | input | 2 | A operand select |
| b_sel | input | 2 | B operand select |
| adc_data | input | 8 | A source 0 |
| spi_word | input | 16 | Upper byte is A source 1, lower byte is B source 2 |
| fsm_val | input | 8 | A source 2 and B source 0 |
| a_const | input | 8 | A source 3 |
| b_const | input | 8 | B source 1 |
| cnt_low | input | 8 | B source 3 |
| pwm_p | output | 1 | Positive PWM output |
| out_n | output | 1 | Complementary PWM or compare match |

## Verification
The bench builds the block with its defaults: W = 8 and DB_UNIT = 1, giving dead bands of 1, 2, 4 and 8 fast cycles and a period of 256 ticks. It drives the divided clock with an 8-cycle period and the routed clock with a 16-cycle period. This makes whole PWM periods short enough to count high cycles exactly, so each dead-band code and both tick sources show up in the expected counts. It also lets the bench place an operand change between a rising and a falling edge, which tells the two clock polarities apart.

// File: rtl/pwmcmp_pkg.sv
package pwmcmp_pkg;
  typedef enum logic {FN_PWM = 1'b0, FN_CMP = 1'b1} fn_e;

  // dead-band length in fast cycles for a code
  function automatic int unsigned db_len(input logic [1:0] code, input int unsigned unit);
    return unit << code;
  endfunction
endpackage

// File: rtl/pwmcmp_tickgen.sv
module pwmcmp_tickgen #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_sel,
  input  logic inv,
  input  logic clk_a,
  input  logic clk_b,
  output logic tick
);
  localparam int NSRC = 2;

  logic [NSRC-1:0] raw_in;
  logic [NSRC-1:0] synced;
  logic            sel_lvl;
  logic            prev_lvl;

  assign raw_in = {clk_b, clk_a};

  for (genvar s = 0; s < NSRC; s++) begin : g_sync
    logic [SYNC-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[SYNC-2:0], raw_in[s]};
    end
    assign synced[s] = chain[SYNC-1];
  end

  assign sel_lvl = synced[src_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_lvl <= 1'b0;
    else        prev_lvl <= sel_lvl;
  end

  assign tick = inv ? (~sel_lvl & prev_lvl) : (sel_lvl & ~prev_lvl);

  // ticks are single-cycle pulses (R8, R9)
  assert_tick_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/pwmcmp_opmux.sv
module pwmcmp_opmux #(
  parameter int W = 8,
  parameter int N = 4
) (
  input  logic [N-1:0][W-1:0]     src,
  input  logic [$clog2(N)-1:0]    sel,
  output logic [W-1:0]            y
);
  always_comb begin
    y = '0;
    for (int i = 0; i < N; i++) begin
      if (sel == i[$clog2(N)-1:0]) y = src[i];
    end
  end
endmodule

// File: rtl/pwmcmp_core.sv
module pwmcmp_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         en,
  input  logic         mode,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         pwm_raw,
  output logic         match
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pwm_raw <= 1'b0;
      match   <= 1'b0;
    end else if (tick) begin
      if (!en) begin
        cnt     <= '0;
        pwm_raw <= 1'b0;
        match   <= 1'b0;
      end else begin
        cnt     <= cnt + 1'b1;
        pwm_raw <= mode ? (cnt <= op_b) : (cnt < op_b);
        match   <= mode ? (op_a >= op_b) : (op_a > op_b);
      end
    end
  end

  // state moves only on the active tick (R9)
  assert_hold_between_ticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(pwm_raw) && $stable(match)));

  // counter held at zero while disabled (R10)
  assert_cnt_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !en) |=> (cnt == '0));
endmodule

// File: rtl/pwmcmp_deadband.sv
module pwmcmp_deadband #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [CW-1:0] dly,
  output logic          out
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      out <= 1'b0;
    end else if (!req) begin
      cnt <= '0;
      out <= 1'b0;
    end else if (cnt >= dly) begin
      out <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // falling edge passes without delay (R4)
  assert_fall_prompt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !out);
endmodule

// File: rtl/pwmcmp_top.sv
module pwmcmp_top #(
  parameter int W       = 8,
  parameter int DB_UNIT = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           func_sel,
  input  logic           mode_sel,
  input  logic [1:0]     db_sel,
  input  logic           clk_inv,
  input  logic           clk_src,
  input  logic           div_clk_in,
  input  logic           route_clk_in,
  input  logic [1:0]     a_sel,
  input  logic [1:0]     b_sel,
  input  logic [W-1:0]   adc_data,
  input  logic [2*W-1:0] spi_word,
  input  logic [W-1:0]   fsm_val,
  input  logic [W-1:0]   a_const,
  input  logic [W-1:0]   b_const,
  input  logic [W-1:0]   cnt_low,
  output logic           pwm_p,
  output logic           out_n
);
  import pwmcmp_pkg::*;

  localparam int NSRC  = 4;
  localparam int MAXD  = DB_UNIT * 8;
  localparam int CW    = $clog2(MAXD + 1);
  localparam int NCH   = 2;

  fn_e                   fn;
  logic                  tick;
  logic [NSRC-1:0][W-1:0] a_src, b_src;
  logic [W-1:0]          op_a, op_b;
  logic                  pwm_raw, match;
  logic [CW-1:0]         dly;
  logic [NCH-1:0]        req, db_out;

  assign fn = fn_e'(func_sel);

  pwmcmp_tickgen #(.SYNC(2)) u_tick (
    .clk(clk), .rst_n(rst_n), .src_sel(clk_src), .inv(clk_inv),
    .clk_a(div_clk_in), .clk_b(route_clk_in), .tick(tick)
  );

  assign a_src = {a_const, fsm_val, spi_word[2*W-1:W], adc_data};
  assign b_src = {cnt_low, spi_word[W-1:0], b_const, fsm_val};

  pwmcmp_opmux #(.W(W), .N(NSRC)) u_mux_a (.src(a_src), .sel(a_sel), .y(op_a));
  pwmcmp_opmux #(.W(W), .N(NSRC)) u_mux_b (.src(b_src), .sel(b_sel), .y(op_b));

  pwmcmp_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .mode(mode_sel),
    .op_a(op_a), .op_b(op_b), .pwm_raw(pwm_raw), .match(match)
  );

  assign dly = CW'(db_len(db_sel, DB_UNIT));
  assign req[0] = en && (fn == FN_PWM) && pwm_raw;
  assign req[1] = en && (fn == FN_PWM) && !pwm_raw;

  for (genvar c = 0; c < NCH; c++) begin : g_db
    pwmcmp_deadband #(.CW(CW)) u_db (
      .clk(clk), .rst_n(rst_n), .req(req[c]), .dly(dly), .out(db_out[c])
    );
  end

  assign pwm_p = db_out[0] && (fn == FN_PWM);
  assign out_n = (fn == FN_CMP) ? (en && match) : db_out[1];

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_p && out_n));

  assert_off_when_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_p);

  assert_cmp_quiet_p_R1: assert property (@(posedge clk) disable iff (!rst_n)
    func_sel |-> !pwm_p);
endmodule

// File: tb/tb_pwmcmp_top.sv
`timescale 1ns/1ps
module tb_pwmcmp_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, func_sel = 1'b0, mode_sel = 1'b0, clk_inv = 1'b0, clk_src = 1'b0;
  logic [1:0] db_sel = 2'd0, a_sel = 2'd0, b_sel = 2'd0;
  logic [7:0] adc_data = '0, fsm_val = '0, a_const = '0, b_const = '0, cnt_low = '0;
  logic [15:0] spi_word = '0;
  logic pwm_p, out_n;
  logic [3:0] divcnt = '0;
  logic div_clk_in, route_clk_in;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always @(negedge clk) divcnt <= divcnt + 1'b1;
  assign div_clk_in   = divcnt[2];
  assign route_clk_in = divcnt[3];

  pwmcmp_top dut (
    .clk(clk), .rst_n(rst_n), .en(en), .func_sel(func_sel), .mode_sel(mode_sel),
    .db_sel(db_sel), .clk_inv(clk_inv), .clk_src(clk_src),
    .div_clk_in(div_clk_in), .route_clk_in(route_clk_in),
    .a_sel(a_sel), .b_sel(b_sel), .adc_data(adc_data), .spi_word(spi_word),
    .fsm_val(fsm_val), .a_const(a_const), .b_const(b_const), .cnt_low(cnt_low),
    .pwm_p(pwm_p), .out_n(out_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_a();
    case (a_sel)
      2'd0: return adc_data;
      2'd1: return spi_word[15:8];
      2'd2: return fsm_val;
      default: return a_const;
    endcase
  endfunction

  function automatic logic [7:0] exp_b();
    case (b_sel)
      2'd0: return fsm_val;
      2'd1: return b_const;
      2'd2: return spi_word[7:0];
      default: return cnt_low;
    endcase
  endfunction

  function automatic int exp_high(input int h, input int t, input int d);
    if (h <= 0) return 0;
    if (h >= 256) return 256 * t;
    return (h * t > d) ? h * t - d : 0;
  endfunction

  task automatic randomize_sources();
    adc_data = 8'($urandom); fsm_val = 8'($urandom); a_const = 8'($urandom);
    b_const  = 8'($urandom); cnt_low = 8'($urandom); spi_word = 16'($urandom);
    a_sel = 2'($urandom); b_sel = 2'($urandom);
  endtask

  task automatic measure(input int n, output int hp, output int hn, output int ov);
    hp = 0; hn = 0; ov = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_p) hp++;
      if (out_n) hn++;
      if (pwm_p && out_n) ov++;
    end
  endtask

  task automatic pwm_case(input string tag);
    int t, d, h, hp, hn, ov;
    t = clk_src ? 16 : 8;
    d = 1 << db_sel;
    h = mode_sel ? int'(exp_b()) + 1 : int'(exp_b());
    repeat (256 * t + 50) @(negedge clk);
    measure(256 * t, hp, hn, ov);
    chk({tag, " R3 R4 pwm_p high cycles"}, hp, exp_high(h, t, d));
    chk({tag, " R1 R4 out_n high cycles"}, hn, exp_high(256 - h, t, d));
    chk({tag, " R5 overlap cycles"}, ov, 0);
  endtask

  task automatic cmp_case(input string tag);
    logic [7:0] a, b;
    int e;
    repeat (30) @(negedge clk);
    a = exp_a(); b = exp_b();
    e = mode_sel ? int'(a >= b) : int'(a > b);
    chk({tag, " R2 R6 R7 match"}, int'(out_n), e);
    chk({tag, " R1 pwm_p low in comparator"}, int'(pwm_p), 0);
  endtask

  task automatic inv_case(input logic inv);
    int hp, hn, ov;
    clk_inv = inv; func_sel = 1'b1; mode_sel = 1'b0;
    a_sel = 2'd3; b_sel = 2'd1; a_const = 8'd10; b_const = 8'd20;
    repeat (40) @(negedge clk);
    chk("R9 compare before step", int'(out_n), 0);
    @(posedge div_clk_in);
    repeat (3) @(posedge clk);
    @(negedge clk);
    a_const = 8'd30;
    repeat (5) @(negedge clk);
    chk(inv ? "R9 falling edge already applied" : "R9 rising edge not yet applied",
        int'(out_n), inv ? 1 : 0);
    repeat (4) @(negedge clk);
    chk("R9 compare after both edges", int'(out_n), 1);
    measure(1, hp, hn, ov);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hp, hn, ov;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 reset pwm_p", int'(pwm_p), 0);
    chk("R10 reset out_n", int'(out_n), 0);

    // disabled, PWM function with a non-trivial duty
    b_sel = 2'd1; b_const = 8'd100;
    measure(300, hp, hn, ov);
    chk("R10 disabled pwm_p cycles", hp, 0);
    chk("R10 disabled out_n cycles", hn, 0);

    en = 1'b1;
    // directed duty corners
    mode_sel = 1'b0; b_sel = 2'd1; b_const = 8'd0; db_sel = 2'd0;
    pwm_case("R3 zero duty");
    mode_sel = 1'b1; b_const = 8'd255; db_sel = 2'd3;
    pwm_case("R3 full duty");
    mode_sel = 1'b0; b_const = 8'd128; db_sel = 2'd2;
    pwm_case("R4 half duty");

    // random PWM, every dead-band code appears
    for (int k = 0; k < 10; k++) begin
      randomize_sources();
      mode_sel = 1'($urandom);
      db_sel = 2'(k);
      pwm_case("R4 R7 random");
    end

    // routed clock source
    clk_src = 1'b1; mode_sel = 1'b0; b_sel = 2'd2; spi_word = 16'h3A40; db_sel = 2'd1;
    pwm_case("R8 routed clock");
    clk_src = 1'b0;

    // comparator function
    func_sel = 1'b1;
    a_sel = 2'd3; b_sel = 2'd1; a_const = 8'd77; b_const = 8'd77;
    mode_sel = 1'b0; cmp_case("R2 equal mode0");
    mode_sel = 1'b1; cmp_case("R2 equal mode1");
    a_const = 8'd78; mode_sel = 1'b0; cmp_case("R2 greater mode0");
    a_const = 8'd76; mode_sel = 1'b1; cmp_case("R2 less mode1");
    for (int k = 0; k < 16; k++) begin
      randomize_sources();
      if (k % 4 == 0) fsm_val = 8'($urandom);
      mode_sel = 1'($urandom);
      cmp_case("R6 R7 random");
    end

    // comparator disabled
    a_sel = 2'd0; adc_data = 8'd200; b_sel = 2'd3; cnt_low = 8'd1; mode_sel = 1'b0;
    cmp_case("R2 before disable");
    en = 1'b0;
    measure(100, hp, hn, ov);
    chk("R10 comparator disabled out_n cycles", hn, 0);
    en = 1'b1;

    inv_case(1'b0);
    inv_case(1'b1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule